// File: doc/BRIEF.md
# Write-Protect Control Register Unit

This block owns the single 8-bit control and status register of a small device that combines a byte-addressed memory with trim (wiper) settings. A host port writes and reads the register. Every memory write request, carrying an 8-bit byte address, and every trim write request is checked against the register's current state. Each request receives a one-cycle grant (`wr_ack`) or refusal (`wr_nack`) in the cycle after it is presented.

Writes are armed in two stages. A global enable latch must be set before anything can be written. A second, register-level enable latch, which can only be set while the global one is set, must be set before the retained fields can be changed: the two lock bits and the two power-on-delay bits. The lock bits protect the top quarter, the top half or the whole of the address space. Any nonzero lock setting also freezes the trim settings.

The volatile latches are cleared by a power-cycle pulse, while the retained fields survive it. A change to the retained fields models a slow programming cycle: `ready` drops for a fixed number of cycles, and during that time every write is refused.

Top module: `wprot_ctrl`

## Requirements
- R1: After `rst`, a register read returns 8'h00 with both flag inputs low, `ready` is 1, and `wr_ack` and `wr_nack` are 0.
- R2: While the global enable (register bit 1) is 0, a register write of 8'h02 sets it and is acknowledged, and every other register write is refused with no change. While the global enable is 1 and the register enable is 0, a write of 8'h00 clears the global enable and is acknowledged.
- R3: The register enable (bit 2) is set only by writing 8'h06 while the global enable is 1. The same write with the global enable at 0 is refused.
- R4: With both enables set, a register write whose bit 2 is 0 copies data bits 7, 4, 3 and 0 into the retained fields, clears the register enable, keeps the global enable and is acknowledged. With the register enable at 0, register writes other than 8'h00, 8'h02 and 8'h06 are refused.
- R5: The read layout is, MSB first: delay-high, flag_a, flag_b, lock-high, lock-low, register enable, global enable, delay-low. Bits 6 and 5 show the flag inputs sampled in the read cycle, and write data in those positions has no effect.
- R6: Lock code {bit4,bit3} 00 protects no address, 01 protects C0h–FFh, 10 protects 80h–FFh, and 11 protects every address.
- R7: A memory write to a protected address is refused and clears the register enable. A memory write to an unprotected address with the global enable set is acknowledged.
- R8: A trim write is acknowledged only when the global enable is 1 and the lock code is 00. Otherwise it is refused.
- R9: While the global enable is 0, memory and trim writes are refused.
- R10: Each accepted request yields exactly one of `wr_ack` or `wr_nack`, high for one cycle, in the cycle after the request.
- R11: Writes that change only the enable latches leave `ready` high. A retained-field write drops `ready` for PROG_CYCLES cycles, and any write presented while `ready` is low is refused.
- R12: A `pwr_cycle` pulse clears both enables and cancels any programming wait. The retained fields keep their values.
- R13: When requests coincide, the register write wins over the memory write, and the memory write wins over the trim write. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset, including the retained fields |
| pwr_cycle | input | 1 | Power-cycle pulse; clears the volatile state only |
| reg_wr_req | input | 1 | Register write request |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_req | input | 1 | Register read request |
| reg_rd_data | output | 8 | Register read data, valid with reg_rd_vld |
| reg_rd_vld | output | 1 | Read data valid, one cycle after reg_rd_req |
| mem_wr_req | input | 1 | Memory write request |
| mem_wr_addr | input | ADDR_W | Memory write byte address |
| trim_wr_req | input | 1 | Trim (wiper) write request |
| flag_a | input | 1 | First external status flag |
| flag_b | input | 1 | Second external status flag |
| wr_ack | output | 1 | Write granted, one-cycle pulse |
| wr_nack | output | 1 | Write refused, one-cycle pulse |
| ready | output | 1 | Low while a retained-field programming wait runs |

## Verification
A wrong enable latch shows at the ports within two cycles. The next write in a suspect state gets the wrong response pulse, and the next read exposes bits 2:1. A wrong lock decode appears only at a boundary address, so the memory writes target 7Fh, 80h, BFh and C0h, plus both ends of the range, under every lock code. A wrong programming-wait length shows as a `ready` low period of the wrong count and as a refusal, or a missing refusal, on a write placed right after a retained update. A retained field wrongly cleared by a power cycle shows on the first read after the pulse.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int REG_W = 8;

  // Bit positions of the packed control/status byte.
  localparam int B_DLY_HI = 7;
  localparam int B_FLAG_A = 6;
  localparam int B_FLAG_B = 5;
  localparam int B_LCK_HI = 4;
  localparam int B_LCK_LO = 3;
  localparam int B_REN    = 2;
  localparam int B_GEN    = 1;
  localparam int B_DLY_LO = 0;

  localparam logic [REG_W-1:0] CMD_GEN_CLR = 8'h00;
  localparam logic [REG_W-1:0] CMD_GEN_SET = 8'h02;
  localparam logic [REG_W-1:0] CMD_REN_SET = 8'h06;

  // Fields that survive a power cycle.
  typedef struct packed {
    logic       dly_hi;
    logic [1:0] lck;
    logic       dly_lo;
  } keep_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REG  = 2'd1,
    SEL_MEM  = 2'd2,
    SEL_TRIM = 2'd3
  } sel_e;

  function automatic logic [REG_W-1:0] pack_status(
    input keep_t k, input logic fa, input logic fb,
    input logic ren, input logic gen);
    logic [REG_W-1:0] v;
    v           = '0;
    v[B_DLY_HI] = k.dly_hi;
    v[B_FLAG_A] = fa;
    v[B_FLAG_B] = fb;
    v[B_LCK_HI] = k.lck[1];
    v[B_LCK_LO] = k.lck[0];
    v[B_REN]    = ren;
    v[B_GEN]    = gen;
    v[B_DLY_LO] = k.dly_lo;
    return v;
  endfunction

endpackage

// File: rtl/wprot_lock_dec.sv
module wprot_lock_dec #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        lck,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              any_lock
);
  logic top_half;
  logic top_quarter;

  assign top_half = addr[ADDR_W-1];

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = &addr[ADDR_W-1 -: 2];
    end else begin : g_narrow
      assign top_quarter = addr[ADDR_W-1];
    end
  endgenerate

  always_comb begin
    unique case (lck)
      2'b00:   hit = 1'b0;
      2'b01:   hit = top_quarter;
      2'b10:   hit = top_half;
      default: hit = 1'b1;
    endcase
  end

  assign any_lock = |lck;
endmodule

// File: rtl/wprot_prog_timer.sv
module wprot_prog_timer #(
  parameter int PROG_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic ready
);
  localparam int CNT_W = (PROG_CYCLES < 1) ? 1 : $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/wprot_latch_ctl.sv
module wprot_latch_ctl
  import wprot_pkg::*;
#(
  parameter logic [3:0] RST_KEEP = 4'b0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_cycle,
  input  logic             reg_go,
  input  logic [REG_W-1:0] reg_data,
  input  logic             lock_hit_go,
  output logic             reg_ok,
  output logic             keep_wr,
  output logic             gen,
  output logic             ren,
  output keep_t            keep
);
  logic is_clr, is_set, is_ren;

  assign is_clr = (reg_data == CMD_GEN_CLR);
  assign is_set = (reg_data == CMD_GEN_SET);
  assign is_ren = (reg_data == CMD_REN_SET);

  // Decide whether the presented register write is legal in the current state.
  always_comb begin
    if (!gen)      reg_ok = is_set;
    else if (!ren) reg_ok = is_clr || is_set || is_ren;
    else           reg_ok = !reg_data[B_REN] || is_ren;
  end

  assign keep_wr = reg_go && gen && ren && !reg_data[B_REN];

  // Volatile latches: cleared by full reset and by a power cycle.
  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      gen <= 1'b0;
      ren <= 1'b0;
    end else if (reg_go && reg_ok) begin
      if (!gen) begin
        gen <= 1'b1;
      end else if (!ren) begin
        if (is_clr) gen <= 1'b0;
        if (is_ren) ren <= 1'b1;
      end else if (!reg_data[B_REN]) begin
        ren <= 1'b0;
      end
    end else if (lock_hit_go) begin
      ren <= 1'b0;
    end
  end

  // Retained fields: only the full reset touches them.
  always_ff @(posedge clk) begin
    if (rst) begin
      keep <= keep_t'(RST_KEEP);
    end else if (keep_wr && !pwr_cycle) begin
      keep.dly_hi <= reg_data[B_DLY_HI];
      keep.lck    <= {reg_data[B_LCK_HI], reg_data[B_LCK_LO]};
      keep.dly_lo <= reg_data[B_DLY_LO];
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PROG_CYCLES = 16,
  parameter logic [3:0] RST_KEEP    = 4'b0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              reg_wr_req,
  input  logic [7:0]        reg_wr_data,
  input  logic              reg_rd_req,
  output logic [7:0]        reg_rd_data,
  output logic              reg_rd_vld,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  input  logic              trim_wr_req,
  input  logic              flag_a,
  input  logic              flag_b,
  output logic              wr_ack,
  output logic              wr_nack,
  output logic              ready
);
  sel_e  sel;
  logic  gen, ren, reg_ok, keep_wr;
  keep_t keep;
  logic  mem_hit, any_lock;
  logic  reg_go, lock_hit_go, grant;
  logic [1:0] cur_lck;

  // Fixed priority: register, then memory, then trim.
  always_comb begin
    if (pwr_cycle)        sel = SEL_NONE;
    else if (reg_wr_req)  sel = SEL_REG;
    else if (mem_wr_req)  sel = SEL_MEM;
    else if (trim_wr_req) sel = SEL_TRIM;
    else                  sel = SEL_NONE;
  end

  assign cur_lck     = keep.lck;
  assign reg_go      = (sel == SEL_REG) && ready;
  assign lock_hit_go = (sel == SEL_MEM) && ready && mem_hit;

  wprot_lock_dec #(.ADDR_W(ADDR_W)) i_lock_dec (
    .lck      (cur_lck),
    .addr     (mem_wr_addr),
    .hit      (mem_hit),
    .any_lock (any_lock)
  );

  wprot_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (pwr_cycle),
    .start (keep_wr && !pwr_cycle),
    .ready (ready)
  );

  wprot_latch_ctl #(.RST_KEEP(RST_KEEP)) i_latch (
    .clk         (clk),
    .rst         (rst),
    .pwr_cycle   (pwr_cycle),
    .reg_go      (reg_go),
    .reg_data    (reg_wr_data),
    .lock_hit_go (lock_hit_go),
    .reg_ok      (reg_ok),
    .keep_wr     (keep_wr),
    .gen         (gen),
    .ren         (ren),
    .keep        (keep)
  );

  always_comb begin
    unique case (sel)
      SEL_REG:  grant = ready && reg_ok;
      SEL_MEM:  grant = ready && gen && !mem_hit;
      SEL_TRIM: grant = ready && gen && !any_lock;
      default:  grant = 1'b0;
    endcase
  end

  // Registered response pulses.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack  <= 1'b0;
      wr_nack <= 1'b0;
    end else begin
      wr_ack  <= (sel != SEL_NONE) && grant;
      wr_nack <= (sel != SEL_NONE) && !grant;
    end
  end

  // Registered read path; flags are sampled in the read cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data <= '0;
      reg_rd_vld  <= 1'b0;
    end else begin
      reg_rd_vld <= reg_rd_req && !pwr_cycle;
      if (reg_rd_req) reg_rd_data <= pack_status(keep, flag_a, flag_b, ren, gen);
    end
  end
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_cycle,
  input logic       reg_wr_req,
  input logic       mem_wr_req,
  input logic       trim_wr_req,
  input logic       mem_hit,
  input logic       gen,
  input logic       ren,
  input logic [1:0] cur_lck,
  input logic       ready,
  input logic       wr_ack,
  input logic       wr_nack
);
  // R10
  ack_nack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_ack && wr_nack));

  // R3
  ren_needs_gen_chk: assert property (@(posedge clk) disable iff (rst)
    ren |-> gen);

  // R12
  pwr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle |=> (!gen && !ren && !wr_ack && !wr_nack));

  // R12
  pwr_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle |=> $stable(cur_lck));

  // R7
  lock_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !reg_wr_req && !pwr_cycle && ready && mem_hit)
      |=> (wr_nack && !ren));

  // R8
  trim_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (trim_wr_req && !reg_wr_req && !mem_wr_req && !pwr_cycle && (cur_lck != 2'b00))
      |=> wr_nack);

  // R11
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && (reg_wr_req || mem_wr_req || trim_wr_req) && !pwr_cycle)
      |=> wr_nack);

  // R9
  gen_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen && !reg_wr_req && (mem_wr_req || trim_wr_req) && !pwr_cycle)
      |=> wr_nack);
endmodule

bind wprot_ctrl wprot_ctrl_chk i_wprot_ctrl_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_cycle   (pwr_cycle),
  .reg_wr_req  (reg_wr_req),
  .mem_wr_req  (mem_wr_req),
  .trim_wr_req (trim_wr_req),
  .mem_hit     (mem_hit),
  .gen         (gen),
  .ren         (ren),
  .cur_lck     (cur_lck),
  .ready       (ready),
  .wr_ack      (wr_ack),
  .wr_nack     (wr_nack)
);

// File: tb/test_wprot_ctrl.sv
`timescale 1ns/1ps
module test_wprot_ctrl;
  localparam int PROG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_cycle = 1'b0;
  logic reg_wr_req = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic reg_rd_req = 1'b0;
  logic [7:0] reg_rd_data;
  logic reg_rd_vld;
  logic mem_wr_req = 1'b0;
  logic [7:0] mem_wr_addr = '0;
  logic trim_wr_req = 1'b0;
  logic flag_a = 1'b0;
  logic flag_b = 1'b0;
  logic wr_ack, wr_nack, ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wprot_ctrl #(.ADDR_W(8), .PROG_CYCLES(PROG)) i_wprot_ctrl (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle),
    .reg_wr_req(reg_wr_req), .reg_wr_data(reg_wr_data),
    .reg_rd_req(reg_rd_req), .reg_rd_data(reg_rd_data), .reg_rd_vld(reg_rd_vld),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .trim_wr_req(trim_wr_req),
    .flag_a(flag_a), .flag_b(flag_b),
    .wr_ack(wr_ack), .wr_nack(wr_nack), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_resp(input bit exp_ok, input string tag);
    chk(wr_ack == exp_ok && wr_nack == !exp_ok, tag,
        {30'd0, wr_ack, wr_nack}, {30'd0, exp_ok, !exp_ok});
  endtask

  task automatic reg_wr(input logic [7:0] d, input bit exp_ok, input string tag);
    @(negedge clk); reg_wr_req = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_req = 1'b0;
    chk_resp(exp_ok, tag);
  endtask

  task automatic mem_wr(input logic [7:0] a, input bit exp_ok, input string tag);
    @(negedge clk); mem_wr_req = 1'b1; mem_wr_addr = a;
    @(negedge clk); mem_wr_req = 1'b0;
    chk_resp(exp_ok, tag);
  endtask

  task automatic trim_wr(input bit exp_ok, input string tag);
    @(negedge clk); trim_wr_req = 1'b1;
    @(negedge clk); trim_wr_req = 1'b0;
    chk_resp(exp_ok, tag);
  endtask

  task automatic reg_rd_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); reg_rd_req = 1'b1;
    @(negedge clk); reg_rd_req = 1'b0;
    chk(reg_rd_vld && reg_rd_data == exp, tag, {23'd0, reg_rd_vld, reg_rd_data}, {23'd0, 1'b1, exp});
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic set_keep(input logic [7:0] d);
    reg_wr(8'h06, 1'b1, "R3 arm");
    reg_wr(d, 1'b1, "R4 keep write");
    wait_ready();
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1 && wr_ack == 1'b0 && wr_nack == 1'b0, "R1 outputs", {ready, wr_ack, wr_nack}, 3'b100);
    reg_rd_chk(8'h00, "R1 reset value");
  endtask

  // R2 R3 R9 R11
  task automatic t_global_enable();
    reg_wr(8'h06, 1'b0, "R3 ren without gen");
    reg_wr(8'h10, 1'b0, "R2 write while disabled");
    reg_rd_chk(8'h00, "R2 no change");
    mem_wr(8'h00, 1'b0, "R9 mem without gen");
    trim_wr(1'b0, "R9 trim without gen");
    reg_wr(8'h02, 1'b1, "R2 set gen");
    chk(ready == 1'b1, "R11 ready after gen write", ready, 1);
    reg_rd_chk(8'h02, "R2 gen visible");
    reg_wr(8'h00, 1'b1, "R2 clear gen");
    reg_rd_chk(8'h00, "R2 gen cleared");
    reg_wr(8'h02, 1'b1, "R2 set gen again");
  endtask

  // R4 R10 R11
  task automatic t_keep_update();
    int n;
    reg_wr(8'h12, 1'b0, "R4 keep write without ren");
    reg_rd_chk(8'h02, "R4 nothing changed");
    reg_wr(8'h06, 1'b1, "R3 set ren");
    chk(ready == 1'b1, "R11 ready after ren write", ready, 1);
    @(negedge clk);
    chk(wr_ack == 1'b0 && wr_nack == 1'b0, "R10 single pulse", {wr_ack, wr_nack}, 0);
    reg_rd_chk(8'h06, "R3 ren visible");
    reg_wr(8'h99, 1'b1, "R4 keep write");
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == PROG, "R11 busy length", n, PROG);
    reg_rd_chk(8'h9B, "R4 fields and ren cleared");
    set_keep(8'h00);
    reg_rd_chk(8'h02, "R4 fields back to zero");
  endtask

  // R5 R11
  task automatic t_flags_busy();
    reg_wr(8'h06, 1'b1, "R3 arm");
    reg_wr(8'h68, 1'b1, "R5 write flag bits");
    mem_wr(8'h00, 1'b0, "R11 mem during busy");
    wait_ready();
    reg_rd_chk(8'h0A, "R5 flag bits ignored on write");
    flag_a = 1'b1; flag_b = 1'b0;
    reg_rd_chk(8'h4A, "R5 flag_a at bit6");
    flag_a = 1'b0; flag_b = 1'b1;
    reg_rd_chk(8'h2A, "R5 flag_b at bit5");
    flag_b = 1'b0;
  endtask

  // R6 R7 R8
  task automatic t_lock_ranges();
    logic [7:0] addrs [6] = '{8'h00, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
    for (int b = 0; b < 4; b++) begin
      set_keep(8'(b << 3));
      for (int i = 0; i < 6; i++) begin
        bit hit;
        hit = (b == 3) || (b == 2 && addrs[i] >= 8'h80) || (b == 1 && addrs[i] >= 8'hC0);
        mem_wr(addrs[i], !hit, $sformatf("R6 lock=%0d addr=%0h", b, addrs[i]));
      end
      trim_wr(b == 0, $sformatf("R8 trim lock=%0d", b));
    end
    set_keep(8'h08);
    reg_wr(8'h06, 1'b1, "R3 arm");
    mem_wr(8'h10, 1'b1, "R7 unlocked mem keeps ren");
    reg_rd_chk(8'h0E, "R7 ren still set");
    mem_wr(8'hC5, 1'b0, "R7 locked mem");
    reg_rd_chk(8'h0A, "R7 ren cleared by locked hit");
  endtask

  // R13
  task automatic t_priority();
    @(negedge clk); mem_wr_req = 1'b1; mem_wr_addr = 8'h00; trim_wr_req = 1'b1;
    @(negedge clk); mem_wr_req = 1'b0; trim_wr_req = 1'b0;
    chk_resp(1'b1, "R13 mem beats trim");
    @(negedge clk); reg_wr_req = 1'b1; reg_wr_data = 8'h00; mem_wr_req = 1'b1;
    @(negedge clk); reg_wr_req = 1'b0; mem_wr_req = 1'b0;
    chk_resp(1'b1, "R13 reg beats mem");
    reg_rd_chk(8'h08, "R13 reg write applied");
    reg_wr(8'h02, 1'b1, "R2 set gen");
  endtask

  // R12
  task automatic t_power_cycle();
    set_keep(8'h91);
    reg_wr(8'h06, 1'b1, "R3 arm");
    @(negedge clk); pwr_cycle = 1'b1;
    @(negedge clk); pwr_cycle = 1'b0;
    reg_rd_chk(8'h91, "R12 volatile cleared, retained kept");
    mem_wr(8'h00, 1'b0, "R12 mem refused after power cycle");
    reg_wr(8'h02, 1'b1, "R2 set gen");
    reg_wr(8'h06, 1'b1, "R3 arm");
    reg_wr(8'h80, 1'b1, "R4 keep write");
    @(negedge clk); pwr_cycle = 1'b1;
    @(negedge clk); pwr_cycle = 1'b0;
    chk(ready == 1'b1, "R12 power cycle cancels wait", ready, 1);
    reg_rd_chk(8'h80, "R12 new retained value kept");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_global_enable();
    t_keep_update();
    t_flags_busy();
    t_lock_ranges();
    t_priority();
    t_power_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule